// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit produces the fetch address for a processor with a 4096-word instruction space. The space is split into four pages of 1024 words. The address is a 2-bit page register followed by a 10-bit in-page offset. Each cycle a small operation code from the sequencer picks what happens to the address:

- hold it;
- step it by one;
- skip one instruction;
- jump or call with a new page taken from the status register;
- add the accumulator for a table lookup;
- return;
- raise a software trap.

A hardware interrupt request takes priority over the operation code. It forces the interrupt vector.

A return stack with a configurable number of entries keeps both the page and the offset of every return point. When a push arrives on a full stack, the oldest entry is overwritten. A pop on an empty stack gives back the entry that was last popped.

Any operation that rewrites the counter, rather than stepping it, costs one extra instruction cycle. The unit raises a stall flag during that following cycle. While the flag is high, the unit ignores the operation code and the interrupt request.

Top module: `pgpc_unit`

## Requirements
- R1: A synchronous active-high reset sets the address to 000H, clears the stall flag and empties the return stack, so that a later pop yields 000H.
- R2: Operation code 1 (step) adds one to the offset, wrapping from 3FFH to 000H inside the same page, and leaves the page bits unchanged.
- R3: Operation code 2 (skip) adds two to the offset, wrapping inside the page, and leaves the page bits unchanged.
- R4: Operation code 3 (jump) loads the 10-bit target into the offset and the page input into the page bits. Operation code 4 (call) does the same, and also pushes the current page with the offset plus one.
- R5: Operation code 5 (table) replaces offset bits 7:0 with (offset bits 7:0 + 1 + accumulator) mod 256. Offset bits 9:8 and the page bits stay unchanged.
- R6: After any skip, jump, call, table, return, trap or accepted interrupt, the stall flag is high for exactly the next cycle. In that cycle the operation code and the interrupt request have no effect, and the address is held.
- R7: An interrupt request in a non-stall cycle overrides the operation code. It sets the address to 001H and pushes the current, unexecuted address.
- R8: Operation code 7 (trap) sets the address to 002H and pushes the current page with the offset plus one.
- R9: Operation code 6 (return) restores the page and offset of the most recent unpopped push, in last-in first-out order.
- R10: A push onto a stack that already holds DEPTH entries overwrites the oldest one. After DEPTH+1 pushes, DEPTH pops return the newest DEPTH entries, newest first.
- R11: A pop on an empty stack returns the most recently popped entry, or 000H if nothing has been popped since reset, and leaves the stack empty.
- R12: Operation code 0 (hold) keeps the address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 hold, 1 step, 2 skip, 3 jump, 4 call, 5 table, 6 return, 7 trap) |
| irq_i | input | 1 | Hardware interrupt request |
| target_i | input | 10 | In-page target for jump and call |
| acc_i | input | 8 | Accumulator value for the table add |
| page_i | input | 2 | Page select bits from the status register |
| addr_o | output | 12 | Current fetch address {page, offset} |
| stall_o | output | 1 | Extra-cycle flag for the sequencer |

## Verification
Assertions check these properties on every cycle:

- The stall flag is never high two cycles running.
- The address is held across a stall.
- A step keeps the page and advances the offset by one with wrap.
- A table add never touches bits 11:8.
- An accepted interrupt lands on 001H.
- The stack occupancy stays bounded, does not grow past full and does not fall below empty.

Only the bench scenarios can show which values come back from the stack, because that depends on history. This covers last-in first-out order across mixed calls, traps and interrupts, the overwrite of the oldest entry after overflow, and the repeated entry returned on underflow. The exact table-add sums, with the carry out of bit 7 dropped, are also shown only by the bench.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

    localparam int PG_W   = 2;
    localparam int OFS_W  = 10;
    localparam int TBL_W  = 8;
    localparam int ADDR_W = PG_W + OFS_W;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_SKIP  = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_TABLE = 3'd5,
        OP_RET   = 3'd6,
        OP_TRAP  = 3'd7
    } pc_op_e;

    typedef struct packed {
        logic [PG_W-1:0]  pg;
        logic [OFS_W-1:0] ofs;
    } pc_loc_t;

    localparam logic [OFS_W-1:0] VEC_RESET = OFS_W'(0);
    localparam logic [OFS_W-1:0] VEC_IRQ   = OFS_W'(1);
    localparam logic [OFS_W-1:0] VEC_TRAP  = OFS_W'(2);

    // In-page advance; the carry out of the offset is dropped (page wrap).
    function automatic logic [OFS_W-1:0] ofs_adv(input logic [OFS_W-1:0] o,
                                                 input logic [1:0] n);
        return o + OFS_W'(n);
    endfunction

    // Table add: only the low TBL_W bits change, upper offset bits kept.
    function automatic logic [OFS_W-1:0] ofs_table(input logic [OFS_W-1:0] o,
                                                   input logic [TBL_W-1:0] acc);
        logic [TBL_W-1:0] low;
        low = o[TBL_W-1:0] + TBL_W'(1) + acc;
        return {o[OFS_W-1:TBL_W], low};
    endfunction

endpackage

// File: rtl/pgpc_stack.sv
module pgpc_stack
    import pgpc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  logic    pop,
    input  pc_loc_t din,
    output pc_loc_t dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    pc_loc_t          mem [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wp_dec;
    logic [PTR_W-1:0] wp_inc;

    assign wp_dec = (wp_q == '0) ? LAST : wp_q - PTR_W'(1);
    assign wp_inc = (wp_q == LAST) ? '0 : wp_q + PTR_W'(1);

    // Non-empty: newest entry sits below the write pointer.
    // Empty: the slot at the pointer holds the entry popped last.
    assign dout = (cnt_q != '0) ? mem[wp_dec] : mem[wp_q];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem[gi] <= '0;
                else if (push && wp_q == PTR_W'(gi))
                    mem[gi] <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            cnt_q <= '0;
        end else if (push) begin
            wp_q <= wp_inc;
            if (cnt_q != FULL)
                cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && cnt_q != '0) begin
            wp_q  <= wp_dec;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);
    p_full_push_r10: assert property (@(posedge clk) disable iff (rst)
        (push && cnt_q == FULL) |=> (cnt_q == FULL));
    p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && $stable(wp_q)));

endmodule

// File: rtl/pgpc_next.sv
module pgpc_next
    import pgpc_pkg::*;
(
    input  logic             stall,
    input  logic             irq,
    input  pc_op_e           op,
    input  pc_loc_t          cur,
    input  logic [OFS_W-1:0] tgt,
    input  logic [TBL_W-1:0] acc,
    input  logic [PG_W-1:0]  page_in,
    input  pc_loc_t          pop_d,
    output pc_loc_t          nxt,
    output logic             push,
    output logic             pop,
    output pc_loc_t          push_d,
    output logic             redirect
);
    pc_loc_t after;

    always_comb begin
        after.pg  = cur.pg;
        after.ofs = ofs_adv(cur.ofs, 2'd1);
    end

    always_comb begin
        nxt      = cur;
        push     = 1'b0;
        pop      = 1'b0;
        push_d   = after;
        redirect = 1'b0;
        if (!stall) begin
            if (irq) begin
                nxt      = '{pg: '0, ofs: VEC_IRQ};
                push     = 1'b1;
                push_d   = cur;
                redirect = 1'b1;
            end else begin
                unique case (op)
                    OP_HOLD: nxt = cur;
                    OP_STEP: nxt = after;
                    OP_SKIP: begin
                        nxt.ofs  = ofs_adv(cur.ofs, 2'd2);
                        redirect = 1'b1;
                    end
                    OP_JUMP: begin
                        nxt      = '{pg: page_in, ofs: tgt};
                        redirect = 1'b1;
                    end
                    OP_CALL: begin
                        nxt      = '{pg: page_in, ofs: tgt};
                        push     = 1'b1;
                        redirect = 1'b1;
                    end
                    OP_TABLE: begin
                        nxt.ofs  = ofs_table(cur.ofs, acc);
                        redirect = 1'b1;
                    end
                    OP_RET: begin
                        nxt      = pop_d;
                        pop      = 1'b1;
                        redirect = 1'b1;
                    end
                    OP_TRAP: begin
                        nxt      = '{pg: '0, ofs: VEC_TRAP};
                        push     = 1'b1;
                        redirect = 1'b1;
                    end
                    default: nxt = cur;
                endcase
            end
        end
    end

endmodule

// File: rtl/pgpc_unit.sv
module pgpc_unit
    import pgpc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic              irq_i,
    input  logic [OFS_W-1:0]  target_i,
    input  logic [TBL_W-1:0]  acc_i,
    input  logic [PG_W-1:0]   page_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              stall_o
);
    pc_loc_t loc_q;
    pc_loc_t loc_d;
    pc_loc_t pop_d;
    pc_loc_t push_d;
    logic    push;
    logic    pop;
    logic    redirect;
    logic    stall_q;
    pc_op_e  op;

    assign op = pc_op_e'(op_i);

    pgpc_next u_next (
        .stall    (stall_q),
        .irq      (irq_i),
        .op       (op),
        .cur      (loc_q),
        .tgt      (target_i),
        .acc      (acc_i),
        .page_in  (page_i),
        .pop_d    (pop_d),
        .nxt      (loc_d),
        .push     (push),
        .pop      (pop),
        .push_d   (push_d),
        .redirect (redirect)
    );

    pgpc_stack #(.DEPTH(DEPTH)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .pop  (pop),
        .din  (push_d),
        .dout (pop_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q   <= '{pg: '0, ofs: VEC_RESET};
            stall_q <= 1'b0;
        end else begin
            loc_q   <= loc_d;
            stall_q <= redirect;
        end
    end

    assign addr_o  = loc_q;
    assign stall_o = stall_q;

    p_stall_single_r6: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> $stable(addr_o));
    p_step_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && !irq_i && op_i == 3'd1) |=>
        (addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W]) &&
         addr_o[OFS_W-1:0] == OFS_W'($past(addr_o[OFS_W-1:0]) + OFS_W'(1))));
    p_table_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && !irq_i && op_i == 3'd5) |=>
        (addr_o[ADDR_W-1:TBL_W] == $past(addr_o[ADDR_W-1:TBL_W])));
    p_irq_vector_r7: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && irq_i) |=> (addr_o == ADDR_W'(1) && stall_o));

endmodule

// File: tb/pgpc_unit_test.sv
module pgpc_unit_test;

    typedef struct packed {
        logic [23:0] tag;
        logic [2:0]  op;
        logic        irq;
        logic [9:0]  tgt;
        logic [7:0]  acc;
        logic [1:0]  pg;
        logic [11:0] addr;
        logic        stall;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{"R2 ", 3'd1, 1'b0, 10'h000, 8'h00, 2'd0, 12'h001, 1'b0},
        '{"R4 ", 3'd3, 1'b0, 10'h3FE, 8'h00, 2'd1, 12'h7FE, 1'b1},
        '{"R12", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'h7FE, 1'b0},
        '{"R2 ", 3'd1, 1'b0, 10'h000, 8'h00, 2'd0, 12'h7FF, 1'b0},
        '{"R2 ", 3'd1, 1'b0, 10'h000, 8'h00, 2'd0, 12'h400, 1'b0},
        '{"R3 ", 3'd2, 1'b0, 10'h000, 8'h00, 2'd0, 12'h402, 1'b1},
        '{"R6 ", 3'd1, 1'b0, 10'h000, 8'h00, 2'd0, 12'h402, 1'b0},
        '{"R5 ", 3'd5, 1'b0, 10'h000, 8'h10, 2'd0, 12'h413, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'h413, 1'b0},
        '{"R4 ", 3'd3, 1'b0, 10'h2F0, 8'h00, 2'd2, 12'hAF0, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hAF0, 1'b0},
        '{"R5 ", 3'd5, 1'b0, 10'h000, 8'h20, 2'd0, 12'hA11, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hA11, 1'b0},
        '{"R4 ", 3'd4, 1'b0, 10'h055, 8'h00, 2'd3, 12'hC55, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hC55, 1'b0},
        '{"R2 ", 3'd1, 1'b0, 10'h000, 8'h00, 2'd0, 12'hC56, 1'b0},
        '{"R7 ", 3'd1, 1'b1, 10'h000, 8'h00, 2'd0, 12'h001, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'h001, 1'b0},
        '{"R8 ", 3'd7, 1'b0, 10'h000, 8'h00, 2'd0, 12'h002, 1'b1},
        '{"R6 ", 3'd0, 1'b1, 10'h000, 8'h00, 2'd0, 12'h002, 1'b0},
        '{"R9 ", 3'd6, 1'b0, 10'h000, 8'h00, 2'd0, 12'h002, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'h002, 1'b0},
        '{"R9 ", 3'd6, 1'b0, 10'h000, 8'h00, 2'd0, 12'hC56, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hC56, 1'b0},
        '{"R9 ", 3'd6, 1'b0, 10'h000, 8'h00, 2'd0, 12'hA12, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hA12, 1'b0},
        '{"R11", 3'd6, 1'b0, 10'h000, 8'h00, 2'd0, 12'hA12, 1'b1},
        '{"R6 ", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hA12, 1'b0},
        '{"R12", 3'd0, 1'b0, 10'h000, 8'h00, 2'd0, 12'hA12, 1'b0}
    };

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'd0;
    logic        irq_i = 1'b0;
    logic [9:0]  target_i = '0;
    logic [7:0]  acc_i = '0;
    logic [1:0]  page_i = '0;
    logic [11:0] addr_o;
    logic        stall_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pgpc_unit #(.DEPTH(DEPTH)) uut (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op_i),
        .irq_i    (irq_i),
        .target_i (target_i),
        .acc_i    (acc_i),
        .page_i   (page_i),
        .addr_o   (addr_o),
        .stall_o  (stall_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic irq,
                        input logic [9:0] tgt, input logic [7:0] acc,
                        input logic [1:0] pg);
        op_i = op; irq_i = irq; target_i = tgt; acc_i = acc; page_i = pg;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "reset addr", addr_o, 12'h000);
        chk("R1", "reset stall", {11'd0, stall_o}, 12'h000);
        rst = 1'b0;

        // Vector walk: steps, wrap, skip, jumps, table adds, calls, irq, trap, returns.
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].op, TBL[i].irq, TBL[i].tgt, TBL[i].acc, TBL[i].pg);
            chk(string'(TBL[i].tag), $sformatf("row %0d addr", i), addr_o, TBL[i].addr);
            chk(string'(TBL[i].tag), $sformatf("row %0d stall", i),
                {11'd0, stall_o}, {11'd0, TBL[i].stall});
        end

        // R1: reset in mid-run returns to 000H and empties the stack.
        step(3'd4, 1'b0, 10'h123, 8'h00, 2'd2);
        op_i = 3'd0; rst = 1'b1;
        @(posedge clk); #1;
        chk("R1", "mid-run reset addr", addr_o, 12'h000);
        chk("R1", "mid-run reset stall", {11'd0, stall_o}, 12'h000);
        rst = 1'b0;
        // R11: pop straight after reset yields 000H.
        step(3'd2, 1'b0, 10'h000, 8'h00, 2'd0);
        step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);
        chk("R3", "skip from reset", addr_o, 12'h002);
        step(3'd6, 1'b0, 10'h000, 8'h00, 2'd0);
        chk("R11", "pop after reset", addr_o, 12'h000);
        step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);

        // R10: DEPTH+1 calls; pushes 001H then 101H..108H.
        for (int k = 0; k <= DEPTH; k++) begin
            step(3'd4, 1'b0, 10'(10'h100 + k), 8'h00, 2'd0);
            step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);
        end
        chk("R4", "last call target", addr_o, 12'(12'h100 + DEPTH));
        for (int k = DEPTH; k >= 1; k--) begin
            step(3'd6, 1'b0, 10'h000, 8'h00, 2'd0);
            chk("R10", $sformatf("overflow pop %0d", k), addr_o, 12'(12'h100 + k));
            step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);
        end
        // R11: oldest entry (001H) was overwritten; underflow repeats 101H.
        step(3'd6, 1'b0, 10'h000, 8'h00, 2'd0);
        chk("R11", "underflow after overflow", addr_o, 12'h101);
        step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);

        // R3: skip wraps inside the page (7FFH -> 401H).
        step(3'd3, 1'b0, 10'h3FF, 8'h00, 2'd1);
        step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);
        step(3'd2, 1'b0, 10'h000, 8'h00, 2'd3);
        chk("R3", "skip wrap", addr_o, 12'h401);
        // R6: irq during the stall cycle is ignored.
        step(3'd3, 1'b1, 10'h0AA, 8'h00, 2'd2);
        chk("R6", "irq in stall ignored", addr_o, 12'h401);
        // R5: table add with acc FFH from 3FFH offset wraps low byte only.
        step(3'd3, 1'b0, 10'h3FF, 8'h00, 2'd0);
        step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);
        step(3'd5, 1'b0, 10'h000, 8'hFF, 2'd1);
        chk("R5", "table low-byte wrap", addr_o, 12'h3FF);
        step(3'd0, 1'b0, 10'h000, 8'h00, 2'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule